// File: doc/BRIEF.md
# Receive Mailbox Acceptance Filter

This block picks a destination mailbox for an incoming frame identifier. A request carries a 29-bit identifier and a flag that says whether the frame uses the extended format. The block compares the request against a bank of receive mailboxes. Each mailbox supplies an active bit, a full bit, a stored format flag and a stored identifier. The block returns a registered result: whether any mailbox accepted the frame, the winning mailbox index, and an overrun indication.

A single policy input selects how the block behaves. With the policy input high, the block uses queueing:
- every mailbox has its own acceptance mask, held in a write-only internal bank;
- the search skips full mailboxes, so successive frames with the same identifier fill a row of mailboxes in turn.

With the policy input low, the block uses first-match:
- three shared masks apply: one general mask, and one dedicated mask for each of two fixed mailboxes;
- the search stops at the first accepting mailbox, even when that mailbox is already full.

Requests use a valid/ready handshake, and results use a valid/ready handshake. The result stage is a single register:
- a new request is taken when that register is empty or is being drained in the same cycle;
- while the consumer holds `res_ready` low, the result stays unchanged and `req_ready` stays low.

Top module: `acf_rx_filter`

## Requirements
- R1: For every mask bit at 1, the corresponding identifier bit of the request must equal the stored identifier bit for a mailbox to accept the frame. A mask bit at 0 makes that bit irrelevant.
- R2: When `req_ext` is 0 (standard frame), only identifier bits [28:18] are compared. When `req_ext` is 1, all 29 bits are compared.
- R3: A mailbox takes part in the search only when its `mb_active` bit is 1 and its `mb_ext` bit equals `req_ext`.
- R4: With `queue_mode`=1, each mailbox is compared under its own mask from the internal bank. The lowest-index accepting mailbox whose `mb_full` bit is 0 wins, and `res_ovr`=0.
- R5: With `queue_mode`=1, when every accepting mailbox is full, the highest-index accepting mailbox wins and `res_ovr`=1.
- R6: With `queue_mode`=0, the lowest-index accepting mailbox wins whether it is full or not. `res_ovr` equals that mailbox's `mb_full` bit.
- R7: With `queue_mode`=0, mailbox 14 uses `share_mask_a`, mailbox 15 uses `share_mask_b`, and every other mailbox uses `share_mask_gen`.
- R8: A write to the internal mask bank (`mask_wr_en`=1) takes effect only when `queue_mode`=1 and `freeze`=1. Under any other condition the write is ignored.
- R9: When no mailbox accepts the frame, the result shows `res_hit`=0, `res_idx`=0 and `res_ovr`=0.
- R10: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1, and its result shows `res_valid`=1 after that edge. `req_ready` is 1 exactly when `res_valid` is 0 or `res_ready` is 1. While `res_valid`=1 and `res_ready`=0, the result fields hold. After reset, `res_valid`=0.
- R11: A request accepted in the same cycle as an effective mask write is judged with the mask value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the result stage |
| queue_mode | input | 1 | 1: per-mailbox masks with queueing search; 0: shared masks with first-match search |
| freeze | input | 1 | Configuration window; mask writes need it high |
| mask_wr_en | input | 1 | Mask bank write strobe |
| mask_wr_idx | input | IDX_W (4) | Mailbox whose mask is written |
| mask_wr_data | input | ID_W (29) | Mask value to write |
| share_mask_gen | input | ID_W (29) | Shared mask for most mailboxes in first-match mode |
| share_mask_a | input | ID_W (29) | Shared mask for mailbox 14 in first-match mode |
| share_mask_b | input | ID_W (29) | Shared mask for mailbox 15 in first-match mode |
| mb_active | input | NUM_MB (16) | Mailbox is an active receive mailbox |
| mb_full | input | NUM_MB (16) | Mailbox already holds an unread frame |
| mb_ext | input | NUM_MB (16) | Stored format flag (1 = extended) |
| mb_id | input | NUM_MB*ID_W (464) | Stored identifiers; mailbox i occupies bits [i*29 +: 29] |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_id | input | ID_W (29) | Incoming frame identifier |
| req_ext | input | 1 | Incoming frame format (1 = extended) |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_hit | output | 1 | Some mailbox accepted the frame |
| res_idx | output | IDX_W (4) | Winning mailbox index |
| res_ovr | output | 1 | Winning mailbox is already full |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a mask-bank write and a match request. The bench raises an effective write to a mailbox's mask on the same edge that it presents a matching request. The result must follow the old mask, and a repeated request on a later edge must follow the new one.

The second pair is a stalled result and a waiting request. The bench holds `res_ready` low while a new request waits. The held result must not change, and the waiting request must be accepted on exactly the edge where the consumer drains the old result.

A behavioural model in the bench predicts `req_ready`, the result fields and the mask bank on every clock and judges both cases.

// File: rtl/acf_pkg.sv
package acf_pkg;
  // Number of identifier bits that take part in a standard-frame compare
  localparam int unsigned STD_ID_W = 11;

  typedef enum logic {
    POL_FIRST = 1'b0,
    POL_QUEUE = 1'b1
  } acf_policy_e;

  typedef struct packed {
    logic hit;
    logic ovr;
  } acf_flags_t;
endpackage

// File: rtl/acf_mask_bank.sv
module acf_mask_bank #(
  parameter int unsigned NUM_MB = 16,
  parameter int unsigned ID_W   = 29,
  localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic                   wr_allow,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [ID_W-1:0]        wr_data,
  output logic [NUM_MB*ID_W-1:0] masks_o
);
  // Storage intentionally has no reset: contents are undefined until written
  logic [ID_W-1:0] mem [NUM_MB];

  always_ff @(posedge clk) begin
    if (wr_en && wr_allow && (int'(wr_idx) < NUM_MB)) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar i = 0; i < NUM_MB; i++) begin : g_out
    assign masks_o[i*ID_W +: ID_W] = mem[i];
  end
endmodule

// File: rtl/acf_mask_sel.sv
module acf_mask_sel #(
  parameter int unsigned NUM_MB = 16,
  parameter int unsigned ID_W   = 29,
  parameter int unsigned SPEC_A = 14,
  parameter int unsigned SPEC_B = 15
) (
  input  acf_pkg::acf_policy_e   policy,
  input  logic [NUM_MB*ID_W-1:0] own_masks,
  input  logic [ID_W-1:0]        gen_mask,
  input  logic [ID_W-1:0]        a_mask,
  input  logic [ID_W-1:0]        b_mask,
  output logic [NUM_MB*ID_W-1:0] eff_masks
);
  for (genvar i = 0; i < NUM_MB; i++) begin : g_sel
    logic [ID_W-1:0] shared_m;
    if (i == SPEC_A) begin : g_a
      assign shared_m = a_mask;
    end else if (i == SPEC_B) begin : g_b
      assign shared_m = b_mask;
    end else begin : g_gen
      assign shared_m = gen_mask;
    end
    assign eff_masks[i*ID_W +: ID_W] =
      (policy == acf_pkg::POL_QUEUE) ? own_masks[i*ID_W +: ID_W] : shared_m;
  end
endmodule

// File: rtl/acf_match_vec.sv
module acf_match_vec #(
  parameter int unsigned NUM_MB = 16,
  parameter int unsigned ID_W   = 29
) (
  input  logic [ID_W-1:0]        req_id,
  input  logic                   req_ext,
  input  logic [NUM_MB-1:0]      mb_active,
  input  logic [NUM_MB-1:0]      mb_ext,
  input  logic [NUM_MB*ID_W-1:0] mb_id,
  input  logic [NUM_MB*ID_W-1:0] masks,
  output logic [NUM_MB-1:0]      hit_o
);
  localparam int unsigned LOW_W = ID_W - acf_pkg::STD_ID_W;

  logic [ID_W-1:0] width_mask;
  assign width_mask = req_ext ? {ID_W{1'b1}}
                              : {{acf_pkg::STD_ID_W{1'b1}}, {LOW_W{1'b0}}};

  for (genvar i = 0; i < NUM_MB; i++) begin : g_cmp
    logic [ID_W-1:0] diff;
    assign diff     = (mb_id[i*ID_W +: ID_W] ^ req_id) & masks[i*ID_W +: ID_W] & width_mask;
    assign hit_o[i] = mb_active[i] && (mb_ext[i] == req_ext) && (diff == '0);
  end
endmodule

// File: rtl/acf_pick.sv
module acf_pick #(
  parameter int unsigned NUM_MB = 16,
  localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
  input  acf_pkg::acf_policy_e policy,
  input  logic [NUM_MB-1:0]    hit_vec,
  input  logic [NUM_MB-1:0]    full_vec,
  output acf_pkg::acf_flags_t  flags_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic [NUM_MB-1:0] free_hit;
  logic [IDX_W-1:0]  first_hit, last_hit, first_free;
  logic              any_hit, any_free;

  assign free_hit = hit_vec & ~full_vec;
  assign any_hit  = |hit_vec;
  assign any_free = |free_hit;

  always_comb begin
    first_hit  = '0;
    first_free = '0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (hit_vec[i])  first_hit  = IDX_W'(i);
      if (free_hit[i]) first_free = IDX_W'(i);
    end
  end

  always_comb begin
    last_hit = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (hit_vec[i]) last_hit = IDX_W'(i);
    end
  end

  always_comb begin
    flags_o.hit = any_hit;
    flags_o.ovr = 1'b0;
    idx_o       = '0;
    if (any_hit) begin
      if (policy == acf_pkg::POL_QUEUE) begin
        if (any_free) begin
          idx_o = first_free;
        end else begin
          idx_o       = last_hit;
          flags_o.ovr = 1'b1;
        end
      end else begin
        idx_o       = first_hit;
        flags_o.ovr = full_vec[first_hit];
      end
    end
  end
endmodule

// File: rtl/acf_rx_filter.sv
module acf_rx_filter #(
  parameter int unsigned NUM_MB = 16,
  parameter int unsigned ID_W   = 29,
  parameter int unsigned SPEC_A = 14,
  parameter int unsigned SPEC_B = 15,
  localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   queue_mode,
  input  logic                   freeze,
  input  logic                   mask_wr_en,
  input  logic [IDX_W-1:0]       mask_wr_idx,
  input  logic [ID_W-1:0]        mask_wr_data,
  input  logic [ID_W-1:0]        share_mask_gen,
  input  logic [ID_W-1:0]        share_mask_a,
  input  logic [ID_W-1:0]        share_mask_b,
  input  logic [NUM_MB-1:0]      mb_active,
  input  logic [NUM_MB-1:0]      mb_full,
  input  logic [NUM_MB-1:0]      mb_ext,
  input  logic [NUM_MB*ID_W-1:0] mb_id,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ID_W-1:0]        req_id,
  input  logic                   req_ext,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic                   res_hit,
  output logic [IDX_W-1:0]       res_idx,
  output logic                   res_ovr
);
  import acf_pkg::*;

  acf_policy_e           policy;
  logic [NUM_MB*ID_W-1:0] own_masks, eff_masks;
  logic [NUM_MB-1:0]     hit_vec;
  acf_flags_t            pick_flags, res_flags;
  logic [IDX_W-1:0]      pick_idx;
  logic                  accept;

  assign policy = queue_mode ? POL_QUEUE : POL_FIRST;

  acf_mask_bank #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_bank (
    .clk      (clk),
    .wr_en    (mask_wr_en),
    .wr_allow (queue_mode & freeze),
    .wr_idx   (mask_wr_idx),
    .wr_data  (mask_wr_data),
    .masks_o  (own_masks)
  );

  acf_mask_sel #(.NUM_MB(NUM_MB), .ID_W(ID_W), .SPEC_A(SPEC_A), .SPEC_B(SPEC_B)) u_sel (
    .policy    (policy),
    .own_masks (own_masks),
    .gen_mask  (share_mask_gen),
    .a_mask    (share_mask_a),
    .b_mask    (share_mask_b),
    .eff_masks (eff_masks)
  );

  acf_match_vec #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_match (
    .req_id    (req_id),
    .req_ext   (req_ext),
    .mb_active (mb_active),
    .mb_ext    (mb_ext),
    .mb_id     (mb_id),
    .masks     (eff_masks),
    .hit_o     (hit_vec)
  );

  acf_pick #(.NUM_MB(NUM_MB)) u_pick (
    .policy   (policy),
    .hit_vec  (hit_vec),
    .full_vec (mb_full),
    .flags_o  (pick_flags),
    .idx_o    (pick_idx)
  );

  // Single result register: refill when empty or draining this cycle
  assign req_ready = ~res_valid | res_ready;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_flags <= '0;
      res_idx   <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_flags <= pick_flags;
      res_idx   <= pick_idx;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assign res_hit = res_flags.hit;
  assign res_ovr = res_flags.ovr;
endmodule

// File: rtl/acf_rx_filter_chk.sv
module acf_rx_filter_chk #(
  parameter int unsigned NUM_MB = 16,
  localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              queue_mode,
  input logic [NUM_MB-1:0] mb_active,
  input logic [NUM_MB-1:0] mb_full,
  input logic              req_valid,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_hit,
  input logic [IDX_W-1:0]  res_idx,
  input logic              res_ovr
);
  // R10: a stalled result keeps every field
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit) && $stable(res_idx) && $stable(res_ovr));

  // R10: an accepted request produces a result on the next edge
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> res_valid);

  // R10: an empty result stage never refuses a request
  assert_empty_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> req_ready);

  // R5/R6: overrun only accompanies a hit
  assert_ovr_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ovr |-> res_hit);

  // R9: a miss reports index 0 and no overrun
  assert_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> (res_idx == '0) && !res_ovr);

  // R3: with no active mailbox nothing can be hit
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !(|mb_active) |=> !res_hit);

  // R4: in queueing mode with no full mailbox there is never an overrun
  assert_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && queue_mode && !(|mb_full) |=> !res_ovr);
endmodule

bind acf_rx_filter acf_rx_filter_chk #(.NUM_MB(NUM_MB)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .queue_mode (queue_mode),
  .mb_active  (mb_active),
  .mb_full    (mb_full),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_hit    (res_hit),
  .res_idx    (res_idx),
  .res_ovr    (res_ovr)
);

// File: tb/acf_rx_filter_tb_top.sv
`timescale 1ns/1ps
module acf_rx_filter_tb_top;
  localparam int N  = 16;
  localparam int W  = 29;
  localparam int IW = 4;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          queue_mode = 1'b1, freeze = 1'b1;
  logic          mask_wr_en = 1'b0;
  logic [IW-1:0] mask_wr_idx = '0;
  logic [W-1:0]  mask_wr_data = '0;
  logic [W-1:0]  share_mask_gen = ONES, share_mask_a = ONES, share_mask_b = ONES;
  logic [N-1:0]  b_act = '0, b_full = '0, b_ext = '0;
  logic [W-1:0]  b_id [N];
  logic [N*W-1:0] mb_id;
  logic          req_valid = 1'b0, req_ext = 1'b1, res_ready = 1'b1;
  logic [W-1:0]  req_id = '0;
  logic          req_ready, res_valid, res_hit, res_ovr;
  logic [IW-1:0] res_idx;

  always_comb begin
    for (int i = 0; i < N; i++) mb_id[i*W +: W] = b_id[i];
  end

  acf_rx_filter dut_i (
    .clk(clk), .rst_n(rst_n), .queue_mode(queue_mode), .freeze(freeze),
    .mask_wr_en(mask_wr_en), .mask_wr_idx(mask_wr_idx), .mask_wr_data(mask_wr_data),
    .share_mask_gen(share_mask_gen), .share_mask_a(share_mask_a), .share_mask_b(share_mask_b),
    .mb_active(b_act), .mb_full(b_full), .mb_ext(b_ext), .mb_id(mb_id),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_ext(req_ext),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_idx(res_idx), .res_ovr(res_ovr)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R10";
  logic [W-1:0] m_mask [N];
  bit ev = 0, eh = 0, eo = 0;
  int ei = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  function automatic void ref_match(output bit h, output int ix, output bit ov);
    int q[$];
    logic [W-1:0] mk;
    for (int i = 0; i < N; i++) begin
      if (!b_act[i] || b_ext[i] != req_ext) continue;
      if (queue_mode) mk = m_mask[i];
      else if (i == 14) mk = share_mask_a;
      else if (i == 15) mk = share_mask_b;
      else mk = share_mask_gen;
      if (!req_ext) mk = mk & {11'h7FF, 18'h0};
      if (((b_id[i] ^ req_id) & mk) == '0) q.push_back(i);
    end
    h = (q.size() > 0); ix = 0; ov = 0;
    if (!h) return;
    if (queue_mode) begin
      ix = -1;
      foreach (q[j]) if (!b_full[q[j]]) begin ix = q[j]; break; end
      if (ix < 0) begin ix = q[q.size()-1]; ov = 1; end
    end else begin
      ix = q[0]; ov = b_full[q[0]];
    end
  endfunction

  // Reference model and per-clock comparison
  always @(posedge clk) begin
    bit acc, h, o;
    int x;
    if (!rst_n) begin
      ev = 0;
    end else begin
      acc = req_valid && (!ev || res_ready);
      if (acc) begin
        ref_match(h, x, o);
        ev = 1; eh = h; ei = x; eo = o;
      end else if (res_ready) begin
        ev = 0;
      end
      if (mask_wr_en && queue_mode && freeze) m_mask[mask_wr_idx] = mask_wr_data;
    end
    #1;
    chk(res_valid == ev, {cur_req, " res_valid"}, int'(res_valid), int'(ev));
    chk(req_ready == (!ev || res_ready), {cur_req, " req_ready"}, int'(req_ready), int'(!ev || res_ready));
    if (ev) begin
      chk(res_hit == eh, {cur_req, " res_hit"}, int'(res_hit), int'(eh));
      chk(int'(res_idx) == ei, {cur_req, " res_idx"}, int'(res_idx), ei);
      chk(res_ovr == eo, {cur_req, " res_ovr"}, int'(res_ovr), int'(eo));
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr_mask(int idx, logic [W-1:0] v);
    @(negedge clk);
    mask_wr_en = 1; mask_wr_idx = IW'(idx); mask_wr_data = v;
    @(negedge clk);
    mask_wr_en = 0;
  endtask

  task automatic clear_mbs();
    @(negedge clk);
    b_act = '0; b_full = '0; b_ext = '0;
    for (int i = 0; i < N; i++) b_id[i] = W'(i * 7919);
  endtask

  task automatic set_mb(int i, bit full, bit ext, logic [W-1:0] id);
    b_act[i] = 1; b_full[i] = full; b_ext[i] = ext; b_id[i] = id;
  endtask

  task automatic do_req(logic [W-1:0] id, bit ext);
    @(negedge clk);
    req_valid = 1; req_id = id; req_ext = ext;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) b_id[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // Load the mask bank in freeze with queueing mode
    for (int i = 0; i < N; i++) wr_mask(i, ONES);
    wr_mask(3, 29'h1FFF_FF00);

    // R1: masked-out low byte of mailbox 3
    cur_req = "R1";
    clear_mbs(); set_mb(3, 0, 1, 29'h0123_4500);
    do_req(29'h0123_45AB, 1);
    do_req(29'h0123_4600, 1);

    // R8: writes outside freeze or outside queueing mode are ignored
    cur_req = "R8";
    clear_mbs(); set_mb(5, 0, 1, 29'h00A5_A5A5);
    freeze = 0; wr_mask(5, '0); freeze = 1;
    do_req(29'h00A5_A5A4, 1);
    queue_mode = 0; wr_mask(5, '0); queue_mode = 1;
    do_req(29'h00A5_A5A4, 1);

    // R4: first free accepting mailbox wins
    cur_req = "R4";
    clear_mbs();
    set_mb(2, 1, 1, 29'h1ABC_DEF0); set_mb(3, 0, 1, 29'h1ABC_DEF0); set_mb(7, 0, 1, 29'h1ABC_DEF0);
    do_req(29'h1ABC_DEF0, 1);
    // R5: all accepting mailboxes full
    cur_req = "R5";
    @(negedge clk); b_full = '1;
    do_req(29'h1ABC_DEF0, 1);

    // R6: first match regardless of full
    cur_req = "R6";
    queue_mode = 0;
    do_req(29'h1ABC_DEF0, 1);
    @(negedge clk); b_full[2] = 0;
    do_req(29'h1ABC_DEF0, 1);

    // R7: dedicated shared masks for mailboxes 14 and 15
    cur_req = "R7";
    clear_mbs();
    set_mb(13, 0, 1, 29'h0000_1230); set_mb(14, 0, 1, 29'h0000_1230); set_mb(15, 0, 1, 29'h0000_4560);
    share_mask_a = 29'h1FFF_FFF0; share_mask_b = 29'h1FFF_FF00;
    do_req(29'h0000_1233, 1);
    do_req(29'h0000_4599, 1);
    do_req(29'h0000_1230, 1);
    share_mask_a = ONES; share_mask_b = ONES;

    // R2: standard frames compare only the top 11 bits
    cur_req = "R2";
    queue_mode = 1;
    clear_mbs(); set_mb(4, 0, 0, {11'h5A3, 18'h00001});
    do_req({11'h5A3, 18'h3FFFF}, 0);
    do_req({11'h5A2, 18'h00001}, 0);

    // R3 / R9: inactive or format-mismatched mailboxes are skipped
    cur_req = "R3";
    clear_mbs(); set_mb(6, 0, 1, 29'h0000_0777); set_mb(9, 0, 0, 29'h0000_0777);
    b_act[6] = 0;
    do_req(29'h0000_0777, 1);
    cur_req = "R9";
    do_req(29'h1000_0000, 0);

    // R10: back-pressure on the result
    cur_req = "R10";
    clear_mbs(); set_mb(1, 0, 1, 29'h11); set_mb(8, 0, 1, 29'h22);
    @(negedge clk); res_ready = 0; req_valid = 1; req_id = 29'h11; req_ext = 1;
    @(negedge clk); req_id = 29'h22;
    repeat (3) @(negedge clk);
    res_ready = 1;
    @(negedge clk); req_valid = 0;
    repeat (2) @(negedge clk);

    // R11: write and match on the same edge
    cur_req = "R11";
    clear_mbs(); set_mb(3, 0, 1, 29'h0123_4500);
    @(negedge clk);
    mask_wr_en = 1; mask_wr_idx = 3; mask_wr_data = ONES;
    req_valid = 1; req_id = 29'h0123_45AB; req_ext = 1;
    @(negedge clk);
    mask_wr_en = 0; req_valid = 0;
    do_req(29'h0123_45AB, 1);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule